// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block sits beside a memory controller and watches the decoded command stream going to a four-bank SDRAM. It raises a separate flag for each spacing rule. Each flag is a single-cycle pulse in the same cycle as the offending command. Minimum spacings that are given in nanoseconds are turned into clock counts at run time from the configured clock period. The counts are rounded up, and the nanosecond values come from one of four speed grades. The block also reports how many read data beats are still valid when a read burst is cut short by a precharge or a burst stop.

Each bank keeps its own open/closed state and its own timers. The ACTIVE-to-ACTIVE spacing across banks is tracked by one shared timer. A flagged command is still applied to the tracked state, so checking carries on from the state the command creates. All flags are zero while reset is held and in the first cycle after it.

Top module: `sdram_timing_checker`

## Requirements
- R1: Every nanosecond minimum becomes a cycle count equal to ceil(ns * 1000 / clk_period_ps). Grades 0..3 use these values: ACT-to-ACT on different banks 15/19/19/30 ns; ACT to RD/WR 19/19/24/30 ns; PRE to ACT 19/19/24/30 ns; ACT to PRE 45/50/60/60 ns; ACT to ACT on the same bank 65/70/84/90 ns.
- R2: Command codes on cmd_i are NOP=0, ACT=1, RD=2, WR=3, PRE=4, BST=5. An ACT to a bank other than the previous ACT's bank, issued fewer cycles after that ACT than the cross-bank count, pulses err_act_act_o.
- R3: An RD or WR to an open bank, issued fewer cycles after its ACT than the ACT-to-column count, pulses err_act_col_o.
- R4: A PRE to an open bank, issued fewer cycles after its ACT than the ACT-to-PRE minimum, pulses err_open_min_o.
- R5: An ACT to a bank, issued fewer cycles after that bank's previous ACT than the same-bank count, pulses err_row_cycle_o.
- R6: An ACT to a bank, issued fewer cycles after a PRE that closed that bank than the PRE-to-ACT count, pulses err_pre_act_o. A PRE to a closed bank changes nothing.
- R7: A PRE to an open bank, issued fewer than W cycles after the last write beat to that bank (a beat in the same cycle counts as 0 cycles), pulses err_wr_pre_o. W is 2. W is 1 only when clk_period_ps > 10000 and manual_pre_i = 1.
- R8: An ACT to a bank, issued fewer than W + (PRE-to-ACT count) cycles after the last write beat to that bank, pulses err_wr_act_o.
- R9: An RD, WR or BST in the same cycle as wr_last_i pulses err_wr_col_o. The beat belongs to the bank of the most recent WR.
- R10: During a PRE or BST, while the most recent column command was an RD, cut_beats_o shows 2 at CAS latency 3, 1 at CAS latency 2 and 0 otherwise. Outside that case it is 0.
- R11: A bank that stays open for more than ceil(100000 ns / period) cycles pulses err_open_max_o once, in the cycle in which its age since ACT first exceeds that count.
- R12: A flagged command still updates the bank state and timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | 2 | Bank addressed by the command |
| wr_last_i | input | 1 | Last write data beat in this cycle |
| clk_period_ps | input | 16 | Clock period in picoseconds |
| cas_lat_i | input | 2 | CAS latency |
| grade_i | input | 2 | Speed grade select |
| manual_pre_i | input | 1 | Manual precharge mode |
| err_act_act_o | output | 1 | Cross-bank ACT spacing broken |
| err_act_col_o | output | 1 | ACT to column spacing broken |
| err_open_min_o | output | 1 | Row closed too early |
| err_open_max_o | output | 1 | Row open too long |
| err_row_cycle_o | output | 1 | Same-bank ACT spacing broken |
| err_pre_act_o | output | 1 | PRE to ACT spacing broken |
| err_wr_pre_o | output | 1 | Write recovery before PRE broken |
| err_wr_act_o | output | 1 | Write recovery before ACT broken |
| err_wr_col_o | output | 1 | Column/BST on last write beat |
| cut_beats_o | output | 2 | Valid beats after an interrupted read |

## Verification
A fixed command walk at 200 MHz, grade 0, contains both early and legal commands for each rule. This separates a rule that fires correctly from one that fires on every command of its kind. A grade-3 run places one cross-bank ACT one cycle inside its limit and another exactly at it, which exposes off-by-one errors and missing round-up. Runs at 80 MHz with manual precharge on and then off show whether write recovery relaxes to one cycle only when both conditions hold. Further runs cover interrupted reads at each CAS latency and a long-open row, which show the beat mapping and that the open-too-long flag fires once, at the right age.

// File: rtl/sdrchk_pkg.sv
// Package: shared command codes and per-grade nanosecond tables.
// Assumes grade index 0..3; all tables are in whole nanoseconds.
package sdrchk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } sdr_cmd_e;

    // Cross-bank ACT spacing per grade.
    function automatic int unsigned ns_act_act(input logic [1:0] g);
        case (g)
            2'd0: return 15;
            2'd1: return 19;
            2'd2: return 19;
            default: return 30;
        endcase
    endfunction

    // ACT to column and PRE to ACT share one table.
    function automatic int unsigned ns_act_col(input logic [1:0] g);
        case (g)
            2'd0: return 19;
            2'd1: return 19;
            2'd2: return 24;
            default: return 30;
        endcase
    endfunction

    // Minimum row open time per grade.
    function automatic int unsigned ns_open_min(input logic [1:0] g);
        case (g)
            2'd0: return 45;
            2'd1: return 50;
            default: return 60;
        endcase
    endfunction

    // Same-bank ACT spacing per grade.
    function automatic int unsigned ns_row_cycle(input logic [1:0] g);
        case (g)
            2'd0: return 65;
            2'd1: return 70;
            2'd2: return 84;
            default: return 90;
        endcase
    endfunction

    // Round-up conversion of nanoseconds to clocks.
    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned per_ps);
        int unsigned p;
        p = (per_ps == 0) ? 1 : per_ps;
        return (ns * 1000 + p - 1) / p;
    endfunction

endpackage

// File: rtl/sdrchk_cycles.sv
// Converts the grade tables to clock counts for the current period.
// Assumes the configuration is quasi-static; results are combinational
// and saturate at the counter widths.
module sdrchk_cycles
    import sdrchk_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int AGE_W      = 28,
    parameter int OPEN_MAX_NS = 100000,
    parameter int SLOW_PS    = 10000
) (
    input  logic [15:0]      per_ps,
    input  logic [1:0]       grade,
    input  logic             manual_pre,
    output logic [CNT_W-1:0] n_act_act,
    output logic [CNT_W-1:0] n_act_col,
    output logic [CNT_W-1:0] n_pre_act,
    output logic [CNT_W-1:0] n_open_min,
    output logic [CNT_W-1:0] n_row_cycle,
    output logic [CNT_W-1:0] n_wr_pre,
    output logic [CNT_W-1:0] n_wr_act,
    output logic [AGE_W-1:0] n_open_max
);
    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
    localparam int unsigned AGE_MAX = (1 << AGE_W) - 3;

    function automatic logic [CNT_W-1:0] sat(input int unsigned v);
        return (v > CNT_MAX) ? CNT_W'(CNT_MAX) : CNT_W'(v);
    endfunction

    int unsigned per;
    int unsigned rp_c;
    int unsigned wr_c;
    int unsigned omax;

    // Per-rule conversions and write-recovery selection.
    always_comb begin
        per         = 32'(per_ps);
        rp_c        = ns_to_clk(ns_act_col(grade), per);
        wr_c        = (manual_pre && per > SLOW_PS) ? 1 : 2;
        omax        = ns_to_clk(OPEN_MAX_NS, per);
        n_act_act   = sat(ns_to_clk(ns_act_act(grade), per));
        n_act_col   = sat(rp_c);
        n_pre_act   = sat(rp_c);
        n_open_min  = sat(ns_to_clk(ns_open_min(grade), per));
        n_row_cycle = sat(ns_to_clk(ns_row_cycle(grade), per));
        n_wr_pre    = sat(wr_c);
        n_wr_act    = sat(wr_c + rp_c);
        n_open_max  = (omax > AGE_MAX) ? AGE_W'(AGE_MAX) : AGE_W'(omax);
    end

endmodule

// File: rtl/sdrchk_bank.sv
// One bank's open state, minimum-spacing down-counters and row age.
// A counter loaded with N-1 at an event reads N-k k cycles later, so a
// nonzero value at a command means fewer than N cycles have passed.
// Assumes at most one command per cycle across all banks.
module sdrchk_bank #(
    parameter int CNT_W = 8,
    parameter int AGE_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             col_i,
    input  logic             pre_i,
    input  logic             last_i,
    input  logic [CNT_W-1:0] n_act_col,
    input  logic [CNT_W-1:0] n_pre_act,
    input  logic [CNT_W-1:0] n_open_min,
    input  logic [CNT_W-1:0] n_row_cycle,
    input  logic [CNT_W-1:0] n_wr_pre,
    input  logic [CNT_W-1:0] n_wr_act,
    input  logic [AGE_W-1:0] n_open_max,
    output logic             e_act_col,
    output logic             e_open_min,
    output logic             e_row_cycle,
    output logic             e_pre_act,
    output logic             e_wr_pre,
    output logic             e_wr_act,
    output logic             e_open_max
);
    logic             open_q;
    logic [CNT_W-1:0] col_q, omin_q, rc_q, rp_q, wp_q, wa_q;
    logic [AGE_W-1:0] age_q;
    logic             do_pre;

    function automatic logic [CNT_W-1:0] ld(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    function automatic logic [CNT_W-1:0] dn(input logic [CNT_W-1:0] c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

    assign do_pre = pre_i & open_q;

    // Open state, spacing counters and row age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            col_q  <= '0;
            omin_q <= '0;
            rc_q   <= '0;
            rp_q   <= '0;
            wp_q   <= '0;
            wa_q   <= '0;
            age_q  <= '0;
        end else begin
            col_q  <= act_i  ? ld(n_act_col)   : dn(col_q);
            omin_q <= act_i  ? ld(n_open_min)  : dn(omin_q);
            rc_q   <= act_i  ? ld(n_row_cycle) : dn(rc_q);
            rp_q   <= do_pre ? ld(n_pre_act)   : dn(rp_q);
            wp_q   <= last_i ? ld(n_wr_pre)    : dn(wp_q);
            wa_q   <= last_i ? ld(n_wr_act)    : dn(wa_q);
            if (act_i) begin
                open_q <= 1'b1;
                age_q  <= AGE_W'(1);
            end else if (do_pre) begin
                open_q <= 1'b0;
                age_q  <= '0;
            end else if (open_q && age_q < n_open_max + AGE_W'(2)) begin
                age_q  <= age_q + 1'b1;
            end
        end
    end

    // Rule checks for the command presented this cycle.
    always_comb begin
        e_act_col   = col_i & open_q & (col_q != '0);
        e_open_min  = do_pre & (omin_q != '0);
        e_wr_pre    = do_pre & ((wp_q != '0) | last_i);
        e_row_cycle = act_i & (rc_q != '0);
        e_pre_act   = act_i & (rp_q != '0);
        e_wr_act    = act_i & ((wa_q != '0) | last_i);
        e_open_max  = open_q & ~act_i & ~do_pre & (age_q == n_open_max + AGE_W'(1));
    end

endmodule

// File: rtl/sdram_timing_checker.sv
// Top: decodes commands, holds the shared cross-bank ACT timer, the
// read/write bookkeeping for burst cut-off and write beats, and one
// tracker per bank. Flags are combinational pulses in the command cycle.
module sdram_timing_checker
    import sdrchk_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int CNT_W       = 8,
    parameter int AGE_W       = 28,
    parameter int OPEN_MAX_NS = 100000,
    parameter int SLOW_PS     = 10000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cmd_i,
    input  logic [1:0]  bank_i,
    input  logic        wr_last_i,
    input  logic [15:0] clk_period_ps,
    input  logic [1:0]  cas_lat_i,
    input  logic [1:0]  grade_i,
    input  logic        manual_pre_i,
    output logic        err_act_act_o,
    output logic        err_act_col_o,
    output logic        err_open_min_o,
    output logic        err_open_max_o,
    output logic        err_row_cycle_o,
    output logic        err_pre_act_o,
    output logic        err_wr_pre_o,
    output logic        err_wr_act_o,
    output logic        err_wr_col_o,
    output logic [1:0]  cut_beats_o
);
    localparam int BA_W = $clog2(NUM_BANKS);

    logic [CNT_W-1:0] n_act_act, n_act_col, n_pre_act, n_open_min;
    logic [CNT_W-1:0] n_row_cycle, n_wr_pre, n_wr_act;
    logic [AGE_W-1:0] n_open_max;

    logic is_act, is_rd, is_wr, is_pre, is_bst;
    logic [CNT_W-1:0] aa_q;
    logic [BA_W-1:0]  last_act_q, wr_bank_q;
    logic             act_seen_q, rd_open_q;
    logic [BA_W-1:0]  ba;

    logic [NUM_BANKS-1:0] b_act_col, b_open_min, b_row_cycle, b_pre_act;
    logic [NUM_BANKS-1:0] b_wr_pre, b_wr_act, b_open_max;

    assign ba = BA_W'(bank_i);

    sdrchk_cycles #(
        .CNT_W(CNT_W), .AGE_W(AGE_W),
        .OPEN_MAX_NS(OPEN_MAX_NS), .SLOW_PS(SLOW_PS)
    ) u_cyc (
        .per_ps(clk_period_ps), .grade(grade_i), .manual_pre(manual_pre_i),
        .n_act_act(n_act_act), .n_act_col(n_act_col), .n_pre_act(n_pre_act),
        .n_open_min(n_open_min), .n_row_cycle(n_row_cycle),
        .n_wr_pre(n_wr_pre), .n_wr_act(n_wr_act), .n_open_max(n_open_max)
    );

    // Command decode.
    always_comb begin
        is_act = (cmd_i == CMD_ACT);
        is_rd  = (cmd_i == CMD_RD);
        is_wr  = (cmd_i == CMD_WR);
        is_pre = (cmd_i == CMD_PRE);
        is_bst = (cmd_i == CMD_BST);
    end

    // Shared ACT timer, last ACT bank, write bank and read-burst marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aa_q       <= '0;
            last_act_q <= '0;
            act_seen_q <= 1'b0;
            wr_bank_q  <= '0;
            rd_open_q  <= 1'b0;
        end else begin
            if (is_act) begin
                aa_q       <= (n_act_act == '0) ? '0 : n_act_act - 1'b1;
                last_act_q <= ba;
                act_seen_q <= 1'b1;
            end else if (aa_q != '0) begin
                aa_q <= aa_q - 1'b1;
            end
            if (is_wr) wr_bank_q <= ba;
            if (is_rd) rd_open_q <= 1'b1;
            else if (is_wr || is_pre || is_bst) rd_open_q <= 1'b0;
        end
    end

    // One tracker per bank.
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(i));
        sdrchk_bank #(.CNT_W(CNT_W), .AGE_W(AGE_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_i(is_act & sel), .col_i((is_rd | is_wr) & sel),
            .pre_i(is_pre & sel),
            .last_i(wr_last_i & (wr_bank_q == BA_W'(i))),
            .n_act_col(n_act_col), .n_pre_act(n_pre_act),
            .n_open_min(n_open_min), .n_row_cycle(n_row_cycle),
            .n_wr_pre(n_wr_pre), .n_wr_act(n_wr_act), .n_open_max(n_open_max),
            .e_act_col(b_act_col[i]), .e_open_min(b_open_min[i]),
            .e_row_cycle(b_row_cycle[i]), .e_pre_act(b_pre_act[i]),
            .e_wr_pre(b_wr_pre[i]), .e_wr_act(b_wr_act[i]),
            .e_open_max(b_open_max[i])
        );
    end

    // Flag merge and cut-off beat count.
    always_comb begin
        err_act_act_o   = is_act & act_seen_q & (ba != last_act_q) & (aa_q != '0);
        err_act_col_o   = |b_act_col;
        err_open_min_o  = |b_open_min;
        err_open_max_o  = |b_open_max;
        err_row_cycle_o = |b_row_cycle;
        err_pre_act_o   = |b_pre_act;
        err_wr_pre_o    = |b_wr_pre;
        err_wr_act_o    = |b_wr_act;
        err_wr_col_o    = wr_last_i & (is_rd | is_wr | is_bst);
        cut_beats_o     = 2'd0;
        if ((is_pre || is_bst) && rd_open_q) begin
            case (cas_lat_i)
                2'd3:    cut_beats_o = 2'd2;
                2'd2:    cut_beats_o = 2'd1;
                default: cut_beats_o = 2'd0;
            endcase
        end
    end

endmodule

// File: rtl/sdram_timing_checker_sva.sv
// Checker: ties each flag to the command kind that alone may raise it.
module sdram_timing_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd_i,
    input logic       wr_last_i,
    input logic [1:0] cas_lat_i,
    input logic       err_act_act_o,
    input logic       err_act_col_o,
    input logic       err_open_min_o,
    input logic       err_row_cycle_o,
    input logic       err_pre_act_o,
    input logic       err_wr_pre_o,
    input logic       err_wr_act_o,
    input logic       err_wr_col_o,
    input logic [1:0] cut_beats_o
);
    a_r2_act_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_act_act_o |-> cmd_i == 3'd1);
    a_r3_col_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_act_col_o |-> (cmd_i == 3'd2 || cmd_i == 3'd3));
    a_r4_pre_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_open_min_o |-> cmd_i == 3'd4);
    a_r5_act_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_row_cycle_o |-> cmd_i == 3'd1);
    a_r6_act_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_pre_act_o |-> cmd_i == 3'd1);
    a_r7_pre_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_wr_pre_o |-> cmd_i == 3'd4);
    a_r8_act_only: assert property (@(posedge clk) disable iff (!rst_n)
        err_wr_act_o |-> cmd_i == 3'd1);
    a_r9_beat_seen: assert property (@(posedge clk) disable iff (!rst_n)
        err_wr_col_o |-> wr_last_i);
    a_r10_beats_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_beats_o != 2'd0) |-> ((cmd_i == 3'd4 || cmd_i == 3'd5) && cas_lat_i >= 2'd2));
    a_r10_beats_max: assert property (@(posedge clk) disable iff (!rst_n)
        cut_beats_o <= 2'd2);
endmodule

bind sdram_timing_checker sdram_timing_checker_sva u_sva (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .wr_last_i(wr_last_i),
    .cas_lat_i(cas_lat_i),
    .err_act_act_o(err_act_act_o), .err_act_col_o(err_act_col_o),
    .err_open_min_o(err_open_min_o), .err_row_cycle_o(err_row_cycle_o),
    .err_pre_act_o(err_pre_act_o), .err_wr_pre_o(err_wr_pre_o),
    .err_wr_act_o(err_wr_act_o), .err_wr_col_o(err_wr_col_o),
    .cut_beats_o(cut_beats_o)
);

// File: tb/sdram_timing_checker_test.sv
module sdram_timing_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  bank = 2'd0;
    logic        last = 1'b0;
    logic [15:0] per = 16'd5000;
    logic [1:0]  cl = 2'd3;
    logic [1:0]  grade = 2'd0;
    logic        mpre = 1'b0;
    logic e_aa, e_ac, e_omin, e_omax, e_rc, e_rp, e_wp, e_wa, e_wc;
    logic [1:0]  beats;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_timing_checker uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .wr_last_i(last),
        .clk_period_ps(per), .cas_lat_i(cl), .grade_i(grade), .manual_pre_i(mpre),
        .err_act_act_o(e_aa), .err_act_col_o(e_ac), .err_open_min_o(e_omin),
        .err_open_max_o(e_omax), .err_row_cycle_o(e_rc), .err_pre_act_o(e_rp),
        .err_wr_pre_o(e_wp), .err_wr_act_o(e_wa), .err_wr_col_o(e_wc),
        .cut_beats_o(beats)
    );

    // Observed word: {aa, ac, omin, omax, rc, rp, wp, wa, wc, beats}
    function automatic logic [10:0] obs();
        return {e_aa, e_ac, e_omin, e_omax, e_rc, e_rp, e_wp, e_wa, e_wc, beats};
    endfunction

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one command at the falling edge and settle before sampling.
    task automatic step(input logic [2:0] c, input logic [1:0] b, input logic l);
        @(negedge clk);
        cmd = c; bank = b; last = l;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd = 3'd0; last = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Grade 0 at 5000 ps: ACT-ACT 3, ACT-col 4, PRE-ACT 4, open-min 9,
    // row cycle 13, write-PRE 2, write-ACT 6. Entry: cmd, bank, last, expect, tag.
    localparam int NV = 17;
    localparam logic [16:0] VEC [NV] = '{
        {3'd1, 2'd0, 1'b0, 11'b000000000_00},  // ACT b0
        {3'd1, 2'd1, 1'b0, 11'b100000000_00},  // R2 early cross-bank ACT
        {3'd0, 2'd0, 1'b0, 11'b000000000_00},
        {3'd0, 2'd0, 1'b0, 11'b000000000_00},
        {3'd1, 2'd2, 1'b0, 11'b000000000_00},  // R2 spacing met, R12 logged
        {3'd2, 2'd1, 1'b0, 11'b000000000_00},  // R3 met
        {3'd2, 2'd0, 1'b0, 11'b000000000_00},
        {3'd4, 2'd2, 1'b0, 11'b001000000_10},  // R4 early PRE, R10 two beats
        {3'd1, 2'd2, 1'b0, 11'b000011000_00},  // R5 R6 early ACT
        {3'd3, 2'd2, 1'b0, 11'b010000000_00},  // R3 early WR
        {3'd0, 2'd2, 1'b1, 11'b000000000_00},  // last beat
        {3'd4, 2'd2, 1'b0, 11'b001000100_00},  // R7 early PRE after write
        {3'd1, 2'd2, 1'b0, 11'b000011010_00},  // R8 early ACT after write
        {3'd3, 2'd3, 1'b1, 11'b000000001_00},  // R9 column on last beat
        {3'd5, 2'd0, 1'b0, 11'b000000000_00},  // R10 no read, no beats
        {3'd4, 2'd0, 1'b0, 11'b000000000_00},  // R4 met
        {3'd0, 2'd0, 1'b0, 11'b000000000_00}
    };
    localparam string TAG [NV] = '{"R12","R2","R12","R12","R2","R3","R3","R4",
        "R5","R3","R7","R7","R8","R9","R10","R4","R12"};

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        do_reset();
        step(3'd0, 2'd0, 1'b0);
        check("R12 reset", obs(), 11'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16:14], VEC[i][13:12], VEC[i][11]);
            check(TAG[i], obs(), VEC[i][10:0]);
        end

        // R1 R2 grade 3 at 5000 ps: cross-bank ACT needs 6 cycles
        grade = 2'd3; do_reset();
        step(3'd1, 2'd0, 1'b0);
        for (int k = 1; k < 5; k++) step(3'd0, 2'd0, 1'b0);
        step(3'd1, 2'd1, 1'b0);
        check("R1 R2 grade3 five cycles", obs(), 11'b100000000_00);
        for (int k = 1; k < 6; k++) step(3'd0, 2'd0, 1'b0);
        step(3'd1, 2'd2, 1'b0);
        check("R1 R2 grade3 six cycles", obs(), 11'd0);

        // R7 R8 80 MHz grade 0 manual precharge: write-PRE 1, PRE-ACT 2, write-ACT 3
        grade = 2'd0; per = 16'd12500; mpre = 1'b1; do_reset();
        step(3'd1, 2'd0, 1'b0);
        step(3'd0, 2'd0, 1'b0);
        step(3'd3, 2'd0, 1'b0);
        step(3'd0, 2'd0, 1'b1);
        step(3'd4, 2'd0, 1'b0);
        check("R7 relaxed PRE", obs(), 11'd0);
        step(3'd0, 2'd0, 1'b0);
        step(3'd1, 2'd0, 1'b0);
        check("R8 relaxed ACT", obs(), 11'd0);

        // R7 same period, automatic mode: write-PRE stays 2
        mpre = 1'b0; do_reset();
        step(3'd1, 2'd0, 1'b0);
        step(3'd0, 2'd0, 1'b0);
        step(3'd3, 2'd0, 1'b0);
        step(3'd0, 2'd0, 1'b1);
        step(3'd4, 2'd0, 1'b0);
        check("R7 strict PRE", obs(), 11'b000000100_00);
        step(3'd0, 2'd0, 1'b0);
        step(3'd1, 2'd0, 1'b0);
        check("R8 strict ACT", obs(), 11'b000000010_00);

        // R10 CAS latency 2 and 1
        per = 16'd5000; cl = 2'd2; do_reset();
        step(3'd2, 2'd0, 1'b0);
        step(3'd5, 2'd0, 1'b0);
        check("R10 cl2", obs(), 11'b000000000_01);
        cl = 2'd1;
        step(3'd2, 2'd0, 1'b0);
        step(3'd5, 2'd0, 1'b0);
        check("R10 cl1", obs(), 11'd0);

        // R11 open-too-long at 5000 ps: limit 20000, pulse at age 20001
        cl = 2'd3; do_reset();
        step(3'd1, 2'd1, 1'b0);
        begin
            int first = 0;
            int pulses = 0;
            for (int k = 1; k <= 20010; k++) begin
                step(3'd0, 2'd0, 1'b0);
                if (e_omax) begin
                    pulses++;
                    if (first == 0) first = k;
                end
            end
            check("R11 pulse age", 11'(first), 11'(20001 % 2048));
            check("R11 pulse count", 11'(pulses), 11'd1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule